// File: doc/BRIEF.md
# Framebuffer Line Fetcher

This block pulls one frame of pixel data out of memory and puts it into an internal FIFO. A pixel engine downstream drains that FIFO. A one-cycle frame-start strobe captures the frame geometry: the base address, the line length in bytes, the number of lines and a signed stride between line starts. With a negative stride the frame can be stored bottom-up. The fetcher then walks the frame and cuts each line into read bursts on a simplified read-address / read-data bus that is 8 bytes wide. No burst crosses the end of a line.

Issue is throttled by two limits. The first is the number of bursts in flight, taken from a bus-options word. The second is the free FIFO space, which counts data already requested. Because of this, returned data always has a FIFO slot waiting. For that reason the read-data channel is never back-pressured and `rd_ready` is held high. The pixel side is valid/ready. A word stays on `px_data` with `px_valid` high until the consumer takes it with `px_ready`, and the consumer may stall for any number of cycles.

Three status pulses are provided. An underrun strobe from the pixel engine freezes request issue until the next frame start. A done pulse marks the last request of a frame. An error pulse marks each error beat. Dropping `enable` abandons the frame and empties the FIFO.

Top module: `fb_line_fetch`

## Requirements
- R1: After reset, `ar_valid`, `px_valid`, `fetch_done` and `bus_err` are all low.
- R2: Line k of a frame starts at base + k × pitch. Inside a line the beats are consecutive 8-byte words. The number of beats per line is `line_bytes` shifted right by 3, so bits [2:0] of `line_bytes` are ignored.
- R3: Each burst carries min(B, beats left in the line) beats. B is `bus_opts[4:0]`, with 0 treated as 1 and values above 16 treated as 16. `ar_len` equals beats − 1, so the last burst of a line is shortened and no burst crosses the end of a line.
- R4: `line_pitch` is a signed 32-bit value, and a negative pitch walks the frame toward lower addresses.
- R5: The number of launched bursts whose last beat has not yet returned never exceeds `bus_opts[11:8]`, with 0 treated as 1.
- R6: A burst is launched only if FIFO occupancy + beats still outstanding + the new burst's beats ≤ DEPTH, so the FIFO never overflows.
- R7: `px_data` delivers the returned beats in the order they arrive. A word is held while `px_valid` is high and `px_ready` is low.
- R8: Once raised, `ar_valid` stays high with `ar_addr` and `ar_len` unchanged until `ar_ready` is seen.
- R9: After the cycle in which `underrun` is high, no new burst is launched until the next `frame_start`. Bursts already requested still deliver their data.
- R10: `fetch_done` pulses for one cycle once the last burst of the last line has been launched. If a frame has zero lines or zero beats per line, it pulses once with no request.
- R11: `bus_err` pulses for one cycle for every read beat returned with `rd_err` set. That beat is still written to the FIFO.
- R12: While `enable` is low, `ar_valid` is low, the FIFO is emptied (`px_valid` low), tracking is cleared and `frame_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Fetcher enable; low aborts the frame |
| frame_start | input | 1 | One-cycle strobe that captures geometry and starts a frame |
| underrun | input | 1 | Strobe from the pixel side that freezes issue for the frame |
| base_addr | input | 32 | Byte address of the first line |
| line_bytes | input | LINE_W | Line length in bytes |
| line_count | input | 12 | Lines per frame |
| line_pitch | input | 32 | Signed byte stride between line starts |
| bus_opts | input | 12 | [4:0] burst beats, [11:8] bursts in flight |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| ar_addr | output | 32 | Burst byte address |
| ar_len | output | 4 | Burst beats minus one |
| rd_valid | input | 1 | Read beat valid |
| rd_ready | output | 1 | Read beat accepted (always high) |
| rd_data | input | 64 | Read beat data |
| rd_last | input | 1 | Last beat of a burst |
| rd_err | input | 1 | Error response on this beat |
| px_valid | output | 1 | FIFO word available |
| px_ready | input | 1 | Consumer takes the word |
| px_data | output | 64 | FIFO head word |
| fetch_done | output | 1 | Last request of the frame launched |
| bus_err | output | 1 | Error beat received |

## Verification
The bench builds the block with DEPTH = 32 and LINE_W = 16. A 32-word FIFO fills after four 8-beat bursts when the consumer stalls, so the space limit can be reached in a short test. A 64-beat line fetched under that stall shows that issue stops at exactly four bursts. The bench's memory responder can hold back its data, which makes the in-flight limit of two bursts and a mid-frame underrun visible within a few dozen cycles. Line lengths of 11 beats and a burst field of 0 give the shortened last burst and the one-beat minimum.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int BEAT_SHIFT = 3;
  localparam int MAX_BURST  = 16;
  localparam int BLEN_W     = 5;

  function automatic logic [BLEN_W-1:0] eff_burst(input logic [4:0] field);
    if (field == 5'd0) return 5'd1;
    else if (field > 5'(MAX_BURST)) return 5'(MAX_BURST);
    else return field;
  endfunction

  function automatic logic [4:0] eff_inflight(input logic [3:0] field);
    return (field == 4'd0) ? 5'd1 : {1'b0, field};
  endfunction
endpackage

// File: rtl/fbf_sync_fifo.sv
module fbf_sync_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_en && !empty) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(rd_en && !empty);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/fbf_credit.sv
module fbf_credit
  import fbf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              launch,
  input  logic [BLEN_W-1:0] req_beats,
  input  logic              pop,
  input  logic              burst_done,
  input  logic [3:0]        max_inflight,
  output logic              credit_ok
);
  localparam int RW = $clog2(DEPTH + 1);

  logic [RW-1:0] resv;
  logic [4:0]    inflight;
  logic [4:0]    cap;

  assign cap       = eff_inflight(max_inflight);
  assign credit_ok = (inflight < cap) &&
                     (int'(resv) + int'(req_beats) <= DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv <= '0; inflight <= '0;
    end else if (flush) begin
      resv <= '0; inflight <= '0;
    end else begin
      resv     <= resv + RW'(launch ? req_beats : '0) - RW'(pop);
      inflight <= inflight + 5'(launch) - 5'(burst_done);
    end
  end

  // R5
  outst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= cap);
  // R6
  resv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(resv) <= DEPTH);
endmodule

// File: rtl/fbf_walker.sv
module fbf_walker
  import fbf_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic              underrun,
  input  logic [31:0]       base_addr,
  input  logic [LINE_W-1:0] line_bytes,
  input  logic [11:0]       line_count,
  input  logic [31:0]       line_pitch,
  input  logic [4:0]        burst_field,
  input  logic              credit_ok,
  input  logic              ar_ready,
  output logic              ar_valid,
  output logic [31:0]       ar_addr,
  output logic [3:0]        ar_len,
  output logic              launch,
  output logic [BLEN_W-1:0] req_beats,
  output logic              fetch_done
);
  logic              active, halted;
  logic [31:0]       line_addr, cur_addr, pitch_q;
  logic [LINE_W-1:0] beats_left, line_beats_q, line_beats_in;
  logic [11:0]       lines_left;
  logic [BLEN_W-1:0] blen;

  assign line_beats_in = line_bytes >> BEAT_SHIFT;
  assign blen          = eff_burst(burst_field);
  assign req_beats     = (beats_left < LINE_W'(blen)) ? BLEN_W'(beats_left) : blen;
  assign launch        = enable && !frame_start && active && !halted &&
                         (!ar_valid || ar_ready) && credit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; halted <= 1'b0; ar_valid <= 1'b0;
      ar_addr <= '0; ar_len <= '0; fetch_done <= 1'b0;
      line_addr <= '0; cur_addr <= '0; pitch_q <= '0;
      beats_left <= '0; line_beats_q <= '0; lines_left <= '0;
    end else begin
      fetch_done <= 1'b0;
      if (!enable) begin
        active <= 1'b0; halted <= 1'b0; ar_valid <= 1'b0;
      end else begin
        if (ar_valid && ar_ready) ar_valid <= 1'b0;
        if (frame_start) begin
          line_addr    <= base_addr;
          cur_addr     <= base_addr;
          pitch_q      <= line_pitch;
          line_beats_q <= line_beats_in;
          beats_left   <= line_beats_in;
          lines_left   <= line_count;
          halted       <= 1'b0;
          if (line_count == '0 || line_beats_in == '0) begin
            active     <= 1'b0;
            fetch_done <= 1'b1;
          end else begin
            active <= 1'b1;
          end
        end else begin
          if (underrun) halted <= 1'b1;
          if (launch) begin
            ar_valid <= 1'b1;
            ar_addr  <= cur_addr;
            ar_len   <= 4'(req_beats - 1'b1);
            if (LINE_W'(req_beats) == beats_left) begin
              if (lines_left == 12'd1) begin
                active     <= 1'b0;
                fetch_done <= 1'b1;
              end else begin
                line_addr  <= line_addr + pitch_q;
                cur_addr   <= line_addr + pitch_q;
                beats_left <= line_beats_q;
                lines_left <= lines_left - 1'b1;
              end
            end else begin
              cur_addr   <= cur_addr + {27'd0, req_beats} * 32'd8;
              beats_left <= beats_left - LINE_W'(req_beats);
            end
          end
        end
      end
    end
  end

  // R8
  ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ar_valid && !ar_ready) |=>
      (!enable || (ar_valid && $stable(ar_addr) && $stable(ar_len))));
  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ar_valid);
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch
  import fbf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic              underrun,
  input  logic [31:0]       base_addr,
  input  logic [LINE_W-1:0] line_bytes,
  input  logic [11:0]       line_count,
  input  logic [31:0]       line_pitch,
  input  logic [11:0]       bus_opts,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [31:0]       ar_addr,
  output logic [3:0]        ar_len,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [63:0]       rd_data,
  input  logic              rd_last,
  input  logic              rd_err,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [63:0]       px_data,
  output logic              fetch_done,
  output logic              bus_err
);
  logic              launch, credit_ok, fifo_empty, fifo_full;
  logic [BLEN_W-1:0] req_beats;
  logic              beat_in, pop, burst_done;
  logic              unused_opt_bits;

  assign unused_opt_bits = ^{bus_opts[7:5], fifo_full};
  assign rd_ready   = 1'b1;
  assign beat_in    = enable && rd_valid;
  assign burst_done = beat_in && rd_last;
  assign px_valid   = !fifo_empty;
  assign pop        = px_valid && px_ready;

  fbf_walker #(.LINE_W(LINE_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
    .underrun(underrun), .base_addr(base_addr), .line_bytes(line_bytes),
    .line_count(line_count), .line_pitch(line_pitch),
    .burst_field(bus_opts[4:0]), .credit_ok(credit_ok), .ar_ready(ar_ready),
    .ar_valid(ar_valid), .ar_addr(ar_addr), .ar_len(ar_len),
    .launch(launch), .req_beats(req_beats), .fetch_done(fetch_done)
  );

  fbf_credit #(.DEPTH(DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n), .flush(!enable), .launch(launch),
    .req_beats(req_beats), .pop(pop), .burst_done(burst_done),
    .max_inflight(bus_opts[11:8]), .credit_ok(credit_ok)
  );

  fbf_sync_fifo #(.DW(64), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!enable), .wr_en(beat_in),
    .wr_data(rd_data), .rd_en(pop), .rd_data(px_data),
    .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= beat_in && rd_err;
  end

  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !px_valid);
  // R7
  px_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && px_valid && !px_ready) |=> (!enable || (px_valid && $stable(px_data))));
endmodule

// File: tb/fb_line_fetch_test.sv
module fb_line_fetch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, frame_start = 1'b0, underrun = 1'b0;
  logic [31:0] base_addr = '0, line_pitch = '0;
  logic [15:0] line_bytes = '0;
  logic [11:0] line_count = '0, bus_opts = 12'h408;
  logic ar_valid, ar_ready = 1'b1;
  logic [31:0] ar_addr;
  logic [3:0] ar_len;
  logic rd_valid = 1'b0, rd_ready, rd_last = 1'b0, rd_err = 1'b0;
  logic [63:0] rd_data = '0;
  logic px_valid, px_ready = 1'b1;
  logic [63:0] px_data;
  logic fetch_done, bus_err;

  int checks = 0, fails = 0;
  logic rsp_hold = 1'b0, log_clr = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;

  always #5 clk = ~clk;

  fb_line_fetch #(.DEPTH(32), .LINE_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
    .underrun(underrun), .base_addr(base_addr), .line_bytes(line_bytes),
    .line_count(line_count), .line_pitch(line_pitch), .bus_opts(bus_opts),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .rd_err(rd_err), .px_valid(px_valid),
    .px_ready(px_ready), .px_data(px_data), .fetch_done(fetch_done),
    .bus_err(bus_err)
  );

  // Memory responder: data of each beat is its own byte address.
  logic [31:0] q_addr [64];
  logic [3:0]  q_len  [64];
  int q_head = 0, q_tail = 0, q_beat = 0;
  always @(posedge clk) begin
    logic [31:0] a;
    if (ar_valid && ar_ready) begin
      q_addr[q_tail % 64] = ar_addr; q_len[q_tail % 64] = ar_len; q_tail = q_tail + 1;
    end
    if (!rd_valid || rd_ready) begin
      if (q_head < q_tail && !rsp_hold) begin
        a = q_addr[q_head % 64] + 32'(q_beat * 8);
        rd_valid <= 1'b1;
        rd_data  <= {32'd0, a};
        rd_err   <= (a == err_addr);
        rd_last  <= (q_beat == int'(q_len[q_head % 64]));
        if (q_beat == int'(q_len[q_head % 64])) begin q_beat = 0; q_head = q_head + 1; end
        else q_beat = q_beat + 1;
      end else begin
        rd_valid <= 1'b0; rd_last <= 1'b0; rd_err <= 1'b0;
      end
    end
  end

  // Monitors
  int ar_cnt, pop_cnt, end_cnt, err_cnt;
  logic [31:0] ar_log [64];
  logic [3:0]  len_log [64];
  logic [63:0] pop_log [128];
  always @(posedge clk) begin
    if (log_clr) begin
      ar_cnt = 0; pop_cnt = 0; end_cnt = 0; err_cnt = 0;
    end else begin
      if (ar_valid && ar_ready) begin
        if (ar_cnt < 64) begin ar_log[ar_cnt] = ar_addr; len_log[ar_cnt] = ar_len; end
        ar_cnt = ar_cnt + 1;
      end
      if (px_valid && px_ready) begin
        if (pop_cnt < 128) pop_log[pop_cnt] = px_data;
        pop_cnt = pop_cnt + 1;
      end
      if (fetch_done) end_cnt = end_cnt + 1;
      if (bus_err) err_cnt = err_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_frame(input logic [31:0] b, input logic [15:0] lb,
                             input logic [11:0] lc, input logic [31:0] p,
                             input logic [11:0] opts);
    @(negedge clk);
    base_addr = b; line_bytes = lb; line_count = lc; line_pitch = p; bus_opts = opts;
    log_clr = 1'b1; frame_start = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; frame_start = 1'b0;
  endtask

  task automatic check_pops(input string tag, input logic [31:0] b, input logic [31:0] p,
                            input int beats, input int lines, input int skip);
    int bad = -1;
    logic [63:0] e = '0;
    for (int l = 0; l < lines; l++)
      for (int k = 0; k < beats; k++) begin
        int i = skip + l * beats + k;
        logic [63:0] ex = {32'd0, b + 32'(l) * p + 32'(k * 8)};
        if (bad < 0 && pop_log[i] !== ex) begin bad = i; e = ex; end
      end
    if (bad < 0) chk(tag, 0, 0);
    else chk(tag, pop_log[bad], e);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 ar_valid", ar_valid, 0);
    chk("R1 px_valid", px_valid, 0);
    chk("R1 flags", {fetch_done, bus_err}, 0);
  endtask

  task automatic test_basic();
    ar_ready = 1'b0;
    start_frame(32'h1000, 16'd64, 12'd3, 32'h100, 12'h408);
    repeat (4) @(negedge clk);
    chk("R8 ar_valid held", ar_valid, 1);
    chk("R8 ar_addr", ar_addr, 32'h1000);
    repeat (6) @(negedge clk);
    chk("R8 ar stable", {ar_valid, ar_addr, ar_len}, {1'b1, 32'h1000, 4'd7});
    ar_ready = 1'b1;
    repeat (150) @(negedge clk);
    chk("R2 burst count", ar_cnt, 3);
    chk("R7 pop count", pop_cnt, 24);
    check_pops("R2 R7 beat order", 32'h1000, 32'h100, 8, 3, 0);
    chk("R10 done once", end_cnt, 1);
  endtask

  task automatic test_split();
    start_frame(32'h2000, 16'h5F, 12'd2, 32'h80, 12'h408);
    repeat (150) @(negedge clk);
    chk("R3 burst count", ar_cnt, 4);
    chk("R3 lens", {len_log[0], len_log[1], len_log[2], len_log[3]}, 16'h7272);
    chk("R3 second burst addr", ar_log[1], 32'h2040);
    check_pops("R2 R3 split data", 32'h2000, 32'h80, 11, 2, 0);
    start_frame(32'h3000, 16'd24, 12'd1, 32'h0, 12'h400);
    repeat (60) @(negedge clk);
    chk("R3 burst field zero count", ar_cnt, 3);
    chk("R3 burst field zero len", {len_log[0], len_log[1], len_log[2]}, 12'h000);
  endtask

  task automatic test_negative();
    start_frame(32'h8000, 16'd16, 12'd3, -32'sd512, 12'h408);
    repeat (100) @(negedge clk);
    chk("R4 last line addr", ar_log[2], 32'h7C00);
    check_pops("R4 bottom-up data", 32'h8000, -32'sd512, 2, 3, 0);
  endtask

  task automatic test_inflight();
    rsp_hold = 1'b1;
    start_frame(32'h4000, 16'd64, 12'd1, 32'h0, 12'h202);
    repeat (40) @(negedge clk);
    chk("R5 bursts while held", ar_cnt, 2);
    rsp_hold = 1'b0;
    repeat (80) @(negedge clk);
    chk("R5 bursts after release", ar_cnt, 4);
    check_pops("R5 data", 32'h4000, 32'h0, 8, 1, 0);
  endtask

  task automatic test_space_abort();
    px_ready = 1'b0;
    start_frame(32'h5000, 16'd512, 12'd1, 32'h0, 12'h808);
    repeat (120) @(negedge clk);
    chk("R6 bursts limited by space", ar_cnt, 4);
    chk("R7 data held", {px_valid, px_data}, {1'b1, 64'h5000});
    enable = 1'b0;
    @(negedge clk);
    chk("R12 fifo flushed", px_valid, 0);
    chk("R12 no request", ar_valid, 0);
    start_frame(32'h6000, 16'd16, 12'd1, 32'h0, 12'h408);
    repeat (30) @(negedge clk);
    chk("R12 start ignored when disabled", ar_cnt, 0);
    px_ready = 1'b1;
    enable = 1'b1;
    start_frame(32'h6000, 16'd16, 12'd1, 32'h0, 12'h408);
    repeat (40) @(negedge clk);
    chk("R12 fresh frame after abort", pop_cnt, 2);
    check_pops("R12 fresh data", 32'h6000, 32'h0, 2, 1, 0);
  endtask

  task automatic test_underrun();
    rsp_hold = 1'b1;
    start_frame(32'h7000, 16'd64, 12'd1, 32'h0, 12'h202);
    repeat (20) @(negedge clk);
    underrun = 1'b1;
    @(negedge clk);
    underrun = 1'b0;
    rsp_hold = 1'b0;
    repeat (80) @(negedge clk);
    chk("R9 no issue after underrun", ar_cnt, 2);
    chk("R9 pending data delivered", pop_cnt, 4);
    chk("R10 no done on frozen frame", end_cnt, 0);
    start_frame(32'h7000, 16'd64, 12'd1, 32'h0, 12'h202);
    repeat (100) @(negedge clk);
    chk("R9 resumes next frame", ar_cnt, 4);
    chk("R10 done on resumed frame", end_cnt, 1);
  endtask

  task automatic test_error_zero();
    err_addr = 32'h9010;
    start_frame(32'h9000, 16'd64, 12'd1, 32'h0, 12'h408);
    repeat (60) @(negedge clk);
    chk("R11 one error pulse", err_cnt, 1);
    chk("R11 error beat kept", pop_cnt, 8);
    err_addr = 32'hFFFF_FFF0;
    start_frame(32'hA000, 16'd64, 12'd0, 32'h0, 12'h408);
    repeat (20) @(negedge clk);
    chk("R10 zero lines done", end_cnt, 1);
    chk("R10 zero lines no request", ar_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    enable = 1'b1;
    test_basic();
    test_split();
    test_negative();
    test_inflight();
    test_space_abort();
    test_underrun();
    test_error_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule